// File: doc/BRIEF.md
# Streamed Affine Map over GF(2^7) Vectors

This block applies an affine transform to a vector of 37 elements, each a 7-bit element of GF(2^7). Every incoming element is first combined by XOR with a stored offset element of the same index. The result then multiplies one complete row of a stored 37x37 coefficient matrix. The scaled row is folded into 37 output accumulators by XOR, so after the last element each accumulator holds one coordinate of the matrix product.

Software or a neighbouring controller fills the matrix and the offset vector through a single-entry write port while the block is idle. It then pulses `start` and streams the 37 input elements in index order, one per accepted cycle, using `in_valid` as a qualifier. `done` rises once the product is complete, and each output coordinate is read back by index.

Top module: `affx_vecmat_top`

## Requirements
- R1: After reset `busy` and `done` are 0 and every output coordinate reads 0.
- R2: A `start` pulse while idle sets `busy`, clears `done` and clears all 37 accumulators at that same clock edge.
- R3: While `busy`, each cycle with `in_valid` high accepts one element. Elements are numbered 0 to 36 in arrival order, and element i is XORed with offset entry i before it is used.
- R4: Output coordinate j equals the XOR over i of (x[i] XOR c[i]) times M[i][j]. The product is taken in GF(2^7) modulo x^7+x+1, with bit k of a value being the coefficient of x^k. For example, 0x40 times 0x02 gives 0x03.
- R5: A cycle with `in_valid` low while `busy` consumes nothing and leaves every accumulator unchanged.
- R6: `busy` falls and `done` rises at the clock edge that accepts element 36. `done` and the outputs then hold until the next accepted `start`.
- R7: A write with `cfg_tgt`=0 stores `cfg_data` in M[`cfg_row`][`cfg_col`]. A write with `cfg_tgt`=1 stores it in c[`cfg_col`], and `cfg_row` is ignored. A write with an index of 37 or more changes nothing.
- R8: Configuration writes made while `busy` is high are ignored.
- R9: A `start` pulse while `busy` is ignored.
- R10: `rd_data` shows accumulator `rd_idx` combinationally, and it shows 0 for an index of 37 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tgt | input | 1 | 0: matrix entry, 1: offset entry |
| cfg_row | input | 6 | Matrix row index |
| cfg_col | input | 6 | Matrix column or offset index |
| cfg_data | input | 7 | Value to store |
| start | input | 1 | Begins a transform when idle |
| in_valid | input | 1 | Input element qualifier |
| in_data | input | 7 | Input element |
| busy | output | 1 | Transform in progress |
| done | output | 1 | Result complete and held |
| rd_idx | input | 6 | Output coordinate select |
| rd_data | output | 7 | Selected output coordinate |

## Verification
An element index that slips by one cycle pairs inputs with the wrong offsets and rows. It corrupts nearly every output coordinate and shows at readout straight after `done`. A faulty subfield reduction corrupts only products whose degree reaches 7, so directed single-entry products check the reduction apart from the accumulation. A lapse in the write lock or the start lock shows as a result that differs from the reference computed with the matrix as loaded. A broken stall shows as `done` rising early or as a wrong sum in the same run.

// File: rtl/affx_pkg.sv
package affx_pkg;
   typedef enum logic {
      CFG_MATRIX = 1'b0,
      CFG_OFFSET = 1'b1
   } cfg_tgt_e;

   localparam int MUL_INTERLEAVE = 0;
   localparam int MUL_PROD_REDUCE = 1;
endpackage

// File: rtl/affx_row_scaler.sv
module affx_row_scaler #(
   parameter int N         = 37,
   parameter int EW        = 7,
   parameter int POLY      = 'h03,
   parameter int MUL_STYLE = 0
) (
   input  logic [EW-1:0]         scale_i,
   input  logic [N-1:0][EW-1:0]  row_i,
   output logic [N-1:0][EW-1:0]  prod_o
);
   import affx_pkg::*;

   localparam int WW = 2*EW - 1;
   localparam logic [EW-1:0] RED  = EW'(POLY);
   localparam logic [EW:0]   FULL = {1'b1, RED};

   for (genvar gc = 0; gc < N; gc++) begin : g_col
      logic [EW-1:0] col_prod;

      if (MUL_STYLE == MUL_INTERLEAVE) begin : g_il
         always_comb begin
            logic [EW-1:0] p;
            p = '0;
            for (int k = EW-1; k >= 0; k--) begin
               p = {p[EW-2:0], 1'b0} ^ (p[EW-1] ? RED : '0);
               if (row_i[gc][k]) p = p ^ scale_i;
            end
            col_prod = p;
         end
      end else begin : g_pr
         always_comb begin
            logic [WW-1:0] w;
            w = '0;
            for (int k = 0; k < EW; k++) begin
               if (row_i[gc][k]) w = w ^ (WW'(scale_i) << k);
            end
            for (int k = WW-1; k >= EW; k--) begin
               if (w[k]) w = w ^ (WW'(FULL) << (k - EW));
            end
            col_prod = w[EW-1:0];
         end
      end

      assign prod_o[gc] = col_prod;
   end
endmodule

// File: rtl/affx_store.sv
module affx_store #(
   parameter int N  = 37,
   parameter int EW = 7,
   parameter int IW = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  lock_i,
   input  logic                  we_i,
   input  logic                  tgt_i,
   input  logic [IW-1:0]         row_i,
   input  logic [IW-1:0]         col_i,
   input  logic [EW-1:0]         data_i,
   input  logic [IW-1:0]         sel_i,
   output logic [N-1:0][EW-1:0]  row_o,
   output logic [EW-1:0]         off_o
);
   import affx_pkg::*;

   logic [N-1:0][EW-1:0] mat_q [N];
   logic [N-1:0][EW-1:0] off_q;
   logic                 wr_ok;
   logic                 row_ok;
   logic                 col_ok;

   assign wr_ok  = we_i & ~lock_i;
   assign row_ok = (32'(row_i) < N);
   assign col_ok = (32'(col_i) < N);

   for (genvar gr = 0; gr < N; gr++) begin : g_row
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mat_q[gr] <= '0;
         end else if (wr_ok && tgt_i == CFG_MATRIX && row_ok && col_ok
                      && 32'(row_i) == gr) begin
            mat_q[gr][col_i] <= data_i;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         off_q <= '0;
      end else if (wr_ok && tgt_i == CFG_OFFSET && col_ok) begin
         off_q[col_i] <= data_i;
      end
   end

   always_comb begin
      row_o = '0;
      off_o = '0;
      for (int i = 0; i < N; i++) begin
         if (32'(sel_i) == i) begin
            row_o = mat_q[i];
            off_o = off_q[i];
         end
      end
   end

   AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      lock_i |=> $stable(off_q) && $stable(mat_q[0])) // R8
      else $error("offset or matrix changed while locked");
endmodule

// File: rtl/affx_ctrl.sv
module affx_ctrl #(
   parameter int N  = 37,
   parameter int IW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          valid_i,
   output logic          clr_o,
   output logic          acc_o,
   output logic [IW-1:0] idx_o,
   output logic          busy_o,
   output logic          done_o
);
   localparam logic [IW-1:0] LAST = IW'(N - 1);

   logic [IW-1:0] idx_q;
   logic          busy_q;
   logic          done_q;

   assign clr_o  = start_i & ~busy_q;
   assign acc_o  = busy_q & valid_i;
   assign idx_o  = idx_q;
   assign busy_o = busy_q;
   assign done_o = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else if (clr_o) begin
         idx_q  <= '0;
         busy_q <= 1'b1;
         done_q <= 1'b0;
      end else if (acc_o) begin
         if (idx_q == LAST) begin
            idx_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> idx_q <= LAST) // R3
      else $error("element index past end");
   AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && valid_i && idx_q == LAST) |=> (done_q && !busy_q)) // R6
      else $error("done not raised after last element");
   AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_q && done_q)) // R6
      else $error("busy and done together");
   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !valid_i) |=> (busy_q && $stable(idx_q))) // R5
      else $error("index moved on a stall");
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start_i && !(valid_i && idx_q == LAST)) |=> busy_q) // R9
      else $error("start disturbed a running transform");
endmodule

// File: rtl/affx_vecmat_top.sv
module affx_vecmat_top #(
   parameter int N         = 37,
   parameter int EW        = 7,
   parameter int POLY      = 'h03,
   parameter int MUL_STYLE = 0,
   parameter int IW        = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic          cfg_tgt,
   input  logic [IW-1:0] cfg_row,
   input  logic [IW-1:0] cfg_col,
   input  logic [EW-1:0] cfg_data,
   input  logic          start,
   input  logic          in_valid,
   input  logic [EW-1:0] in_data,
   output logic          busy,
   output logic          done,
   input  logic [IW-1:0] rd_idx,
   output logic [EW-1:0] rd_data
);
   import affx_pkg::*;

   if (N < 2) begin : g_bad_n
      $error("N must be at least 2");
   end
   if (EW < 2) begin : g_bad_ew
      $error("EW must be at least 2");
   end
   if (IW < $clog2(N)) begin : g_bad_iw
      $error("IW too narrow for N");
   end
   if ((POLY % 2) == 0 || POLY >= (1 << EW)) begin : g_bad_poly
      $error("POLY must be odd and fit in EW bits");
   end
   if (MUL_STYLE != MUL_INTERLEAVE && MUL_STYLE != MUL_PROD_REDUCE) begin : g_bad_style
      $error("unknown MUL_STYLE");
   end

   logic                 clr;
   logic                 acc_en;
   logic [IW-1:0]        idx;
   logic [N-1:0][EW-1:0] row;
   logic [EW-1:0]        off;
   logic [EW-1:0]        scale;
   logic [N-1:0][EW-1:0] prod;
   logic [N-1:0][EW-1:0] acc_q;

   affx_ctrl #(.N(N), .IW(IW)) ctrl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .valid_i (in_valid),
      .clr_o   (clr),
      .acc_o   (acc_en),
      .idx_o   (idx),
      .busy_o  (busy),
      .done_o  (done)
   );

   affx_store #(.N(N), .EW(EW), .IW(IW)) store_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .lock_i (busy),
      .we_i   (cfg_we),
      .tgt_i  (cfg_tgt),
      .row_i  (cfg_row),
      .col_i  (cfg_col),
      .data_i (cfg_data),
      .sel_i  (idx),
      .row_o  (row),
      .off_o  (off)
   );

   assign scale = in_data ^ off;

   affx_row_scaler #(.N(N), .EW(EW), .POLY(POLY), .MUL_STYLE(MUL_STYLE)) scaler_i (
      .scale_i (scale),
      .row_i   (row),
      .prod_o  (prod)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clr) begin
         acc_q <= '0;
      end else if (acc_en) begin
         acc_q <= acc_q ^ prod;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int j = 0; j < N; j++) begin
         if (32'(rd_idx) == j) rd_data = acc_q[j];
      end
   end

   AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (acc_q == '0)) // R2
      else $error("accumulators not cleared on start");
   AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(busy && in_valid) && !(start && !busy)) |=> $stable(acc_q)) // R5
      else $error("accumulators moved without an accepted element");
endmodule

// File: tb/affx_vecmat_top_tb_top.sv
`timescale 1ns/1ps
module affx_vecmat_top_tb_top;
   localparam int N  = 37;
   localparam int EW = 7;
   localparam int IW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic          cfg_tgt = 1'b0;
   logic [IW-1:0] cfg_row = '0;
   logic [IW-1:0] cfg_col = '0;
   logic [EW-1:0] cfg_data = '0;
   logic          start = 1'b0;
   logic          in_valid = 1'b0;
   logic [EW-1:0] in_data = '0;
   logic          busy;
   logic          done;
   logic [IW-1:0] rd_idx = '0;
   logic [EW-1:0] rd_data;

   int checks = 0;
   int errors = 0;

   logic [EW-1:0] tm [N][N];
   logic [EW-1:0] tc [N];
   logic [EW-1:0] tx [N];
   logic [EW-1:0] ty [N];

   always #2.5 clk = ~clk;

   affx_vecmat_top dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tgt(cfg_tgt),
      .cfg_row(cfg_row), .cfg_col(cfg_col), .cfg_data(cfg_data),
      .start(start), .in_valid(in_valid), .in_data(in_data),
      .busy(busy), .done(done), .rd_idx(rd_idx), .rd_data(rd_data)
   );

   function automatic logic [EW-1:0] gmul(input logic [EW-1:0] a, input logic [EW-1:0] b);
      logic [EW-1:0] r = '0;
      logic [EW-1:0] s = a;
      for (int k = 0; k < EW; k++) begin
         if (b[k]) r ^= s;
         s = s[EW-1] ? ({s[EW-2:0], 1'b0} ^ 7'h03) : {s[EW-2:0], 1'b0};
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic compute_ref();
      for (int j = 0; j < N; j++) begin
         ty[j] = '0;
         for (int i = 0; i < N; i++) ty[j] ^= gmul(tx[i] ^ tc[i], tm[i][j]);
      end
   endtask

   task automatic cfg_write(input bit tgt, input int row, input int col, input int val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_tgt = tgt; cfg_row = IW'(row); cfg_col = IW'(col); cfg_data = EW'(val);
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic load_all();
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) cfg_write(1'b0, i, j, int'(tm[i][j]));
      for (int i = 0; i < N; i++) cfg_write(1'b1, 0, i, int'(tc[i]));
   endtask

   // mode 0: plain, 1: random stalls, 2: disturb with writes and start while busy
   task automatic run_vec(input int mode, input string req);
      @(negedge clk);
      start = 1'b1; rd_idx = '0;
      @(posedge clk); #1;
      chk(busy && !done, "R2", {busy, done}, 2'b10);
      chk(rd_data == 0, "R2", rd_data, 0);
      @(negedge clk); start = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (mode == 1 && ($urandom % 3) == 0) begin
            in_valid = 1'b0; in_data = EW'($urandom);
            @(posedge clk); #1;
            chk(busy && !done, "R5", {busy, done}, 2'b10);
            @(negedge clk);
         end
         in_valid = 1'b1; in_data = tx[i];
         if (mode == 2 && i == 10) begin
            start = 1'b1;
            cfg_we = 1'b1; cfg_tgt = 1'b0; cfg_row = 0; cfg_col = 0; cfg_data = ~tm[0][0];
         end
         if (mode == 2 && i == 11) begin
            start = 1'b0;
            cfg_we = 1'b1; cfg_tgt = 1'b1; cfg_row = 0; cfg_col = 20; cfg_data = ~tc[20];
         end
         if (mode == 2 && i == 12) cfg_we = 1'b0;
         if (i == N-1) chk(!done, "R6", done, 0);
         @(posedge clk); #1;
         @(negedge clk);
      end
      in_valid = 1'b0;
      chk(done && !busy, "R6", {busy, done}, 2'b01);
      compute_ref();
      for (int j = 0; j < N; j++) begin
         rd_idx = IW'(j); #0.1;
         chk(rd_data == ty[j], req, rd_data, ty[j]);
      end
      rd_idx = IW'(45); #0.1;
      chk(rd_data == 0, "R10", rd_data, 0);
   endtask

   task automatic set_identity();
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) tm[i][j] = (i == j) ? 7'h01 : 7'h00;
   endtask

   initial begin
      #(5.0 * 200000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      // R1: reset state
      chk(!busy && !done, "R1", {busy, done}, 0);
      for (int j = 0; j < N; j++) begin
         rd_idx = IW'(j); #0.1;
         chk(rd_data == 0, "R1", rd_data, 0);
      end

      // R4 R7: identity matrix, zero offset returns the input
      set_identity();
      for (int i = 0; i < N; i++) begin tc[i] = '0; tx[i] = EW'($urandom); end
      load_all();
      run_vec(0, "R4");
      for (int j = 0; j < N; j++) begin
         rd_idx = IW'(j); #0.1;
         chk(rd_data == tx[j], "R7", rd_data, tx[j]);
      end

      // R3: identity with random offset gives input XOR offset
      for (int i = 0; i < N; i++) begin tc[i] = EW'($urandom); cfg_write(1'b1, 5, i, int'(tc[i])); end
      run_vec(0, "R3");

      // R4: directed reduction corner, 0x40 * 0x02 = 0x03
      for (int i = 0; i < N; i++) begin
         tc[i] = '0; tx[i] = '0;
         for (int j = 0; j < N; j++) tm[i][j] = '0;
      end
      tm[0][0] = 7'h40; tx[0] = 7'h02;
      tm[1][3] = 7'h7F; tx[1] = 7'h7F;
      tm[36][36] = 7'h55; tx[36] = 7'h2A;
      load_all();
      run_vec(0, "R4");
      rd_idx = 0; #0.1;
      chk(rd_data == 7'h03, "R4", rd_data, 7'h03);

      // R4: random matrices and offsets
      for (int t = 0; t < 2; t++) begin
         for (int i = 0; i < N; i++) begin
            tc[i] = EW'($urandom); tx[i] = EW'($urandom);
            for (int j = 0; j < N; j++) tm[i][j] = EW'($urandom);
         end
         load_all();
         run_vec(0, "R4");
      end

      // R5: stalls in the input stream
      for (int i = 0; i < N; i++) tx[i] = EW'($urandom);
      run_vec(1, "R5");

      // R6: done and outputs hold while idle
      repeat (4) @(posedge clk);
      #1;
      chk(done && !busy, "R6", {busy, done}, 2'b01);
      rd_idx = 7; #0.1;
      chk(rd_data == ty[7], "R6", rd_data, ty[7]);

      // R8 R9: writes and start during a run are ignored
      run_vec(2, "R8");
      run_vec(0, "R9");

      // R7: out-of-range writes change nothing
      cfg_write(1'b0, 37, 0, 7'h11);
      cfg_write(1'b0, 0, 40, 7'h22);
      cfg_write(1'b1, 0, 63, 7'h33);
      run_vec(0, "R7");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule